// File: doc/BRIEF.md
# Auto-Increment Video RAM Port

This block lets a processor reach a word-wide video memory indirectly, through a handful of word registers at small byte offsets. Software first loads a word pointer and a stride. It then writes data words to a single data register. Each data write lands at the pointer, and the pointer then moves on by the stride. The stride is a full 16-bit value and the sum wraps at 16 bits, so a stride of 0xFFFF walks backwards by one word. A read of the data register returns the word under the pointer and leaves the pointer where it is.

The same register window also holds several other registers:
- a 16-bit display control word;
- a 32-bit raster interrupt position, loaded as two independent 16-bit halves;
- an acknowledge strobe, which stores nothing and only pulses an output.

A 32-bit write is split into two word writes. The upper half goes first, to the given offset, and the lower half follows at offset+2. A long write at the pointer register therefore sets the pointer and then stores one data word.

Requests arrive on a valid/ready stream, and read results leave on a second valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in two cases:
- while the second half of a split long write is being applied;
- while a read result is held on `rsp_*` and `rsp_ready` is low.

Once `rsp_valid` rises, `rsp_valid` and `rsp_rdata` stay unchanged until a clock edge on which `rsp_ready` is high.

The memory has 2^RAM_AW words (default 1024). It is indexed by the low RAM_AW bits of the 16-bit pointer, so higher pointer bits alias onto the same words. A 64K-word memory is obtained with RAM_AW=16.

Top module: `vram_autoinc_port`

## Requirements
- R1: After reset, the pointer, stride, display control and interrupt position all read zero; `irq_ack` and `rsp_valid` are low and `req_ready` is high.
- R2: A word write at offset 0x0 loads the pointer, at offset 0x4 loads the stride and at offset 0x6 loads the display control word, each visible on its output one cycle after acceptance.
- R3: A word write at offset 0x2 stores the data at memory word `ptr[RAM_AW-1:0]`, then sets the pointer to (pointer + stride) mod 2^16; a stride of 0xFFFF decrements, and the pointer wraps past 0xFFFF to 0x0000.
- R4: A word write at offset 0x8 replaces bits 31:16 of the interrupt position and keeps bits 15:0.
- R5: A word write at offset 0xA replaces bits 15:0 of the interrupt position and keeps bits 31:16.
- R6: A write at offset 0xC raises `irq_ack` for exactly one cycle and changes no stored register.
- R7: A long write (`req_long`=1) applies `req_wdata[31:16]` at the given offset, then `req_wdata[15:0]` at offset+2 on the next cycle; `req_ready` is low during that second cycle.
- R8: A read at offset 0x2 returns the memory word at the pointer one cycle after acceptance and leaves the pointer unchanged; a read at any other offset returns 0x0000.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay stable and `req_ready` is low.
- R10: A write to any offset other than 0x0, 0x2, 0x4, 0x6, 0x8, 0xA or 0xC (including odd offsets) changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = 32-bit write split into two word writes |
| req_ofs | input | 16 | Low 16 byte-address bits selecting the register |
| req_wdata | input | 32 | Write data; only bits 15:0 are used for word writes |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Read result taken on this edge |
| rsp_rdata | output | 16 | Read result |
| vid_ptr | output | 16 | Current word pointer |
| vid_step | output | 16 | Current stride |
| disp_ctrl | output | 16 | Display control word |
| irq_pos | output | 32 | Raster interrupt position |
| irq_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
The data register is exercised with:
- a unit stride over consecutive words, which separates store-then-advance from advance-then-store;
- a stride of 0xFFFF starting at pointer zero, which shows the 16-bit wrap going backwards and the aliasing of the top pointer word into the small memory;
- a large stride across 0xFFFF, which shows the wrap going forwards.

The interrupt position is written as two halves in both orders, which catches a half that clobbers its neighbour. Long writes are sent to the pointer register and to the interrupt register to check the order of the two halves. Reads are made both with the response accepted at once and with the response held back, to separate a pointer that moves on a read, a response that changes while it is held, and a request accepted during a stall.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
  localparam int WORD_W = 16;
  localparam int OFS_W  = 16;
  localparam int IRQ_W  = 32;

  localparam logic [OFS_W-1:0] OFS_PTR    = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_DATA   = 16'h0002;
  localparam logic [OFS_W-1:0] OFS_STEP   = 16'h0004;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 16'h0006;
  localparam logic [OFS_W-1:0] OFS_IRQ_HI = 16'h0008;
  localparam logic [OFS_W-1:0] OFS_IRQ_LO = 16'h000A;
  localparam logic [OFS_W-1:0] OFS_ACK    = 16'h000C;

  typedef struct packed {
    logic              wr;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] data;
  } word_op_t;
endpackage

// File: rtl/vram_req_split.sv
module vram_req_split
  import vram_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_write,
  input  logic                in_long,
  input  logic [OFS_W-1:0]    in_ofs,
  input  logic [2*WORD_W-1:0] in_wdata,
  output logic                op_valid,
  input  logic                op_ready,
  output word_op_t            op
);
  logic     pend;
  word_op_t held;
  logic     split_fire;

  assign in_ready   = !pend && op_ready;
  assign split_fire = in_valid && in_ready && in_write && in_long;

  always_comb begin
    if (pend) begin
      op_valid = 1'b1;
      op       = held;
    end else begin
      op_valid = in_valid;
      op.wr    = in_write;
      op.ofs   = in_ofs;
      op.data  = (in_write && in_long) ? in_wdata[2*WORD_W-1:WORD_W]
                                       : in_wdata[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      held <= '0;
    end else if (pend) begin
      if (op_ready) pend <= 1'b0;
    end else if (split_fire) begin
      pend      <= 1'b1;
      held.wr   <= 1'b1;
      held.ofs  <= in_ofs + OFS_W'(2);
      held.data <= in_wdata[WORD_W-1:0];
    end
  end

  // R7: the lower half follows at offset+2 on the next cycle
  assert_low_half_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    split_fire |=> (op_valid && op.wr && op.ofs == $past(in_ofs) + OFS_W'(2)
                    && op.data == $past(in_wdata[WORD_W-1:0])));

  // R7: no new request is taken while the second half is pending
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    split_fire |=> !in_ready);
endmodule

// File: rtl/vram_ctrl_regs.sv
module vram_ctrl_regs
  import vram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  word_op_t          op,
  output logic [WORD_W-1:0] ptr,
  output logic [WORD_W-1:0] step,
  output logic [WORD_W-1:0] ctrl,
  output logic [IRQ_W-1:0]  irq_pos,
  output logic              irq_ack,
  output logic              data_wr,
  output logic              data_rd
);
  localparam int HALVES = IRQ_W / WORD_W;

  logic wr_fire;
  assign wr_fire = fire && op.wr;
  assign data_wr = wr_fire && (op.ofs == OFS_DATA);
  assign data_rd = fire && !op.wr && (op.ofs == OFS_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_fire && op.ofs == OFS_PTR) begin
      ptr <= op.data;
    end else if (data_wr) begin
      ptr <= ptr + step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      ctrl <= '0;
      irq_ack <= 1'b0;
    end else begin
      if (wr_fire && op.ofs == OFS_STEP) step <= op.data;
      if (wr_fire && op.ofs == OFS_CTRL) ctrl <= op.data;
      irq_ack <= wr_fire && (op.ofs == OFS_ACK);
    end
  end

  // g = 0 is the low half at 0xA, g = 1 the high half at 0x8
  for (genvar g = 0; g < HALVES; g++) begin : g_irq
    localparam logic [OFS_W-1:0] HALF_OFS = OFS_IRQ_LO - OFS_W'(2 * g);
    logic [WORD_W-1:0] half_q;
    always_ff @(posedge clk) begin
      if (!rst_n) half_q <= '0;
      else if (wr_fire && op.ofs == HALF_OFS) half_q <= op.data;
    end
    assign irq_pos[g*WORD_W +: WORD_W] = half_q;
  end

  // R3: the pointer moves only on a pointer load or a data write
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && (op.ofs == OFS_PTR || op.ofs == OFS_DATA)) |=> $stable(ptr));

  // R3: a data write advances by the stride held at the time of the write
  assert_ptr_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ptr == WORD_W'($past(ptr) + $past(step)));

  // R4: the high-half write keeps the low half
  assert_irq_lo_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op.ofs == OFS_IRQ_HI) |=>
      irq_pos[WORD_W-1:0] == $past(irq_pos[WORD_W-1:0]));

  // R5: the low-half write keeps the high half
  assert_irq_hi_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op.ofs == OFS_IRQ_LO) |=>
      irq_pos[IRQ_W-1:WORD_W] == $past(irq_pos[IRQ_W-1:WORD_W]));

  // R6: an acknowledge pulses and leaves every register as it was
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op.ofs == OFS_ACK) |=>
      (irq_ack && $stable(ptr) && $stable(step) && $stable(ctrl) && $stable(irq_pos)));
endmodule

// File: rtl/vram_store.sv
module vram_store #(
  parameter int AW = 10,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/vram_rsp_stage.sv
module vram_rsp_stage
  import vram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_is_data,
  input  logic [WORD_W-1:0] ram_q,
  output logic              slot_free,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata
);
  logic from_ram;

  assign slot_free = !rsp_valid || rsp_ready;
  assign rsp_rdata = from_ram ? ram_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      from_ram  <= 1'b0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      from_ram  <= rd_is_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a held result does not move
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/vram_autoinc_port.sv
module vram_autoinc_port
  import vram_port_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_long,
  input  logic [OFS_W-1:0]    req_ofs,
  input  logic [2*WORD_W-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic [WORD_W-1:0]   vid_ptr,
  output logic [WORD_W-1:0]   vid_step,
  output logic [WORD_W-1:0]   disp_ctrl,
  output logic [IRQ_W-1:0]    irq_pos,
  output logic                irq_ack
);
  logic        op_valid;
  logic        op_ready;
  word_op_t    op;
  logic        op_fire;
  logic        data_wr;
  logic        data_rd;
  logic        rd_fire;
  logic [WORD_W-1:0] ram_q;

  assign op_fire = op_valid && op_ready;
  assign rd_fire = op_fire && !op.wr;

  vram_req_split i_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_write (req_write),
    .in_long  (req_long),
    .in_ofs   (req_ofs),
    .in_wdata (req_wdata),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .op       (op)
  );

  vram_ctrl_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (op_fire),
    .op      (op),
    .ptr     (vid_ptr),
    .step    (vid_step),
    .ctrl    (disp_ctrl),
    .irq_pos (irq_pos),
    .irq_ack (irq_ack),
    .data_wr (data_wr),
    .data_rd (data_rd)
  );

  vram_store #(.AW(RAM_AW), .W(WORD_W)) i_store (
    .clk   (clk),
    .we    (data_wr),
    .waddr (vid_ptr[RAM_AW-1:0]),
    .wdata (op.data),
    .re    (data_rd),
    .raddr (vid_ptr[RAM_AW-1:0]),
    .q     (ram_q)
  );

  vram_rsp_stage i_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .rd_is_data (data_rd),
    .ram_q      (ram_q),
    .slot_free  (op_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata)
  );

  // R9: no request is taken while a result is held back
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R8: a read of the data register leaves the pointer alone
  assert_read_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> $stable(vid_ptr));
endmodule

// File: tb/test_vram_autoinc_port.sv
module test_vram_autoinc_port;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_long;
  logic [15:0] req_ofs;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [15:0] rsp_rdata;
  logic [15:0] vid_ptr, vid_step, disp_ctrl;
  logic [31:0] irq_pos;
  logic        irq_ack;

  always #10 clk = ~clk;

  vram_autoinc_port #(.RAM_AW(AW)) i_vram_autoinc_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_long(req_long), .req_ofs(req_ofs), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .vid_ptr(vid_ptr), .vid_step(vid_step), .disp_ctrl(disp_ctrl),
    .irq_pos(irq_pos), .irq_ack(irq_ack)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] mram [1 << AW];
  logic [15:0] m_ptr = '0, m_step = '0, m_ctrl = '0;
  logic [31:0] m_irq = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] ofs, logic [15:0] d);
    case (ofs)
      16'h0: m_ptr = d;
      16'h2: begin mram[m_ptr[AW-1:0]] = d; m_ptr = m_ptr + m_step; end
      16'h4: m_step = d;
      16'h6: m_ctrl = d;
      16'h8: m_irq[31:16] = d;
      16'hA: m_irq[15:0] = d;
      default: ;
    endcase
  endtask

  task automatic send(logic w, logic l, logic [15:0] ofs, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_long = l; req_ofs = ofs; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [15:0] ofs, logic [15:0] d);
    send(1'b1, 1'b0, ofs, {16'h0, d});
    apply(ofs, d);
  endtask

  task automatic wr_long(logic [15:0] ofs, logic [31:0] d);
    send(1'b1, 1'b1, ofs, d);
    check("R7", "req_ready during second half", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    apply(ofs, d[31:16]);
    apply(ofs + 16'd2, d[15:0]);
  endtask

  task automatic rd(logic [15:0] ofs);
    exp_q.push_back(ofs == 16'h2 ? mram[m_ptr[AW-1:0]] : 16'h0000);
    send(1'b0, 1'b0, ofs, 32'h0);
  endtask

  task automatic check_regs(string req);
    check(req, "vid_ptr", {16'h0, vid_ptr}, {16'h0, m_ptr});
    check(req, "vid_step", {16'h0, vid_step}, {16'h0, m_step});
    check(req, "disp_ctrl", {16'h0, disp_ctrl}, {16'h0, m_ctrl});
    check(req, "irq_pos", irq_pos, m_irq);
  endtask

  // scoreboard monitor: R8 read results
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected response", {16'h0, rsp_rdata}, 32'hFFFF_FFFF);
      end else begin
        check("R8", "read data", {16'h0, rsp_rdata}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    req_valid = 0; req_write = 0; req_long = 0; req_ofs = '0; req_wdata = '0;
    rsp_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    check("R1", "irq_ack", {31'b0, irq_ack}, 32'd0);
    check("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1", "req_ready", {31'b0, req_ready}, 32'd1);

    // R2 register loads
    wr(16'h0, 16'h0010);
    check("R2", "vid_ptr", {16'h0, vid_ptr}, 32'h10);
    wr(16'h4, 16'h0001);
    wr(16'h6, 16'hA5A5);
    check_regs("R2");

    // R3 unit stride
    wr(16'h2, 16'h1111);
    wr(16'h2, 16'h2222);
    wr(16'h2, 16'h3333);
    check("R3", "vid_ptr after 3 writes", {16'h0, vid_ptr}, 32'h13);

    // R8 read does not advance
    wr(16'h0, 16'h0010);
    rd(16'h2);
    check("R8", "vid_ptr after read", {16'h0, vid_ptr}, 32'h10);
    wr(16'h0, 16'h0011);
    rd(16'h2);

    // R3 decrement with wrap and aliasing
    wr(16'h4, 16'hFFFF);
    wr(16'h0, 16'h0000);
    wr(16'h2, 16'hBEEF);
    check("R3", "vid_ptr wraps down", {16'h0, vid_ptr}, 32'hFFFF);
    wr(16'h2, 16'hCAFE);
    check("R3", "vid_ptr decrement", {16'h0, vid_ptr}, 32'hFFFE);
    wr(16'h0, 16'h0000);
    rd(16'h2);
    wr(16'h0, 16'hFFFF);
    rd(16'h2);

    // R3 large stride wrapping upwards
    wr(16'h4, 16'h0100);
    wr(16'h0, 16'hFF80);
    wr(16'h2, 16'h4242);
    check("R3", "vid_ptr wraps up", {16'h0, vid_ptr}, 32'h0080);

    // R4 / R5 interrupt position halves
    wr(16'h8, 16'h1234);
    wr(16'hA, 16'h5678);
    check("R5", "irq_pos", irq_pos, 32'h1234_5678);
    wr(16'h8, 16'hABCD);
    check("R4", "irq_pos", irq_pos, 32'hABCD_5678);

    // R6 acknowledge
    wr(16'hC, 16'h0007);
    check("R6", "irq_ack pulse", {31'b0, irq_ack}, 32'd1);
    check_regs("R6");
    @(negedge clk);
    check("R6", "irq_ack drops", {31'b0, irq_ack}, 32'd0);

    // R7 long writes
    wr(16'h4, 16'h0002);
    wr_long(16'h0, 32'h0200_7777);
    check("R7", "vid_ptr after long", {16'h0, vid_ptr}, 32'h0202);
    wr(16'h0, 16'h0200);
    rd(16'h2);
    wr_long(16'h8, 32'h0BAD_F00D);
    check("R7", "irq_pos after long", irq_pos, 32'h0BAD_F00D);

    // R10 unlisted offsets ignored
    wr(16'hE, 16'h9999);
    wr(16'h3, 16'h9999);
    wr(16'h1, 16'h9999);
    check_regs("R10");
    rd(16'h2);
    rd(16'h6);

    // R9 back-pressure
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    rsp_ready = 1'b0;
    rd(16'h2);
    held = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      check("R9", "rsp_valid held", {31'b0, rsp_valid}, 32'd1);
      check("R9", "req_ready low", {31'b0, req_ready}, 32'd0);
      check("R9", "rsp_rdata stable", {16'h0, rsp_rdata}, {16'h0, held});
      @(negedge clk);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "queue drained", exp_q.size(), 32'd0);
    check("R8", "vid_ptr after reads", {16'h0, vid_ptr}, {16'h0, m_ptr});
    finish_run();
  end
endmodule